// File: doc/BRIEF.md
# Policy-Selectable Direct-Mapped Data Cache

This block is a small direct-mapped data cache. It sits between a single requester and a backing memory. The requester issues one word access at a time over a valid/ready handshake and receives a one-cycle response pulse for every access. Reads carry data in that pulse; writes use it to mark completion. The memory side moves a whole line in one beat. A per-word strobe lets single-word writes go straight through to memory.

Three live inputs set the behaviour. The first picks how a write hit is handled: write-through or write-back. The second picks how a write miss is handled: allocate or no-allocate. The third bypasses the array completely. The block samples all three when it accepts a request, so changing them while an access is in flight has no effect on that access. Dirty lines survive a change from write-back to write-through and are still written out when another tag replaces them.

Top module: `policy_cache`

## Requirements
- R1: While rst_ni is low and right after it rises, req_ready_o is 1, rsp_valid_o is 0 and mem_req_o is 0. Reset invalidates every line, so the first read after reset makes a line read.
- R2: A read hit produces rsp_valid_o with the cached word in the cycle after acceptance, with no memory transaction.
- R3: A read miss issues one line read (mem_we_o=0) at mem_addr_o = word address with the offset bits removed. The address layout, from the top bit down, is tag, then set index, then word offset. It returns word `offset` of the line (bits offset*DATA_W upward) after the fill.
- R4: With write-through selected (wt_mode_i=1), a write hit updates the line. It also issues exactly one memory write whose mem_wstrb_o has only bit `offset` set, before the response.
- R5: With write-back selected (wt_mode_i=0), a write hit updates only the line, marks it dirty, responds in the next cycle and makes no memory transaction.
- R6: A fill that replaces a valid dirty line first writes the whole old line to its own line address, with all strobe bits set, and then reads the new line.
- R7: With no-allocate selected (walloc_i=0), a write miss makes exactly one strobed word write and leaves the cache unchanged.
- R8: With allocate selected (walloc_i=1), a write miss fills the line and then completes as a write hit under the selected write-hit policy.
- R9: With cache_dis_i=1, a read makes one line read and returns the memory word, and a write makes one word write. Neither looks up nor changes cache state.
- R10: Dirty lines written in write-back mode stay dirty after a switch to write-through and are written back when evicted.
- R11: mem_req_o stays high with stable address, direction and strobe until mem_ack_i. req_ready_o is low while a memory transaction is outstanding.
- R12: The policy inputs are sampled at request acceptance; changing them later does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wt_mode_i | input | 1 | 1 = write-through on write hit, 0 = write-back |
| walloc_i | input | 1 | 1 = allocate on write miss, 0 = write around |
| cache_dis_i | input | 1 | 1 = every access goes straight to memory |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | ADDR_W | Word address |
| req_we_i | input | 1 | 1 = write |
| req_wdata_i | input | DATA_W | Write word |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Read word, valid with rsp_valid_o on reads |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | 1 = memory write |
| mem_addr_o | output | ADDR_W-log2(LINE_WORDS) | Line address |
| mem_wstrb_o | output | LINE_WORDS | Per-word write strobe |
| mem_wdata_o | output | LINE_WORDS*DATA_W | Line write data |
| mem_ack_i | input | 1 | One-cycle transaction acknowledge |
| mem_rdata_i | input | LINE_WORDS*DATA_W | Line read data, valid with mem_ack_i |

## Verification
On every cycle, assertions check the memory handshake holding steady until acknowledge, the single-word strobe on word writes, and that an eviction only ever starts from a valid dirty line. They also check that a dirty bit never sits on an invalid line, that a fill leaves a clean valid line, and that a read hit yields the stored word one cycle later. The bench's scenarios are the only way to show the policy-level outcomes. These include the number and kind of memory transactions for each access under all four policy combinations, and stale reads through the disable path that leave cached dirty data intact. They also include dirty lines outliving a switch to write-through, policy changes after acceptance being ignored, and the final backing memory matching a flat reference.

// File: rtl/policy_cache_pkg.sv
package policy_cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_WORD_WR,
    ST_LINE_RD
  } pc_state_e;

endpackage

// File: rtl/policy_cache_tags.sv
module policy_cache_tags #(
  parameter int SETS  = 8,
  parameter int TAG_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [$clog2(SETS)-1:0]  idx_i,
  output logic                     valid_o,
  output logic                     dirty_o,
  output logic [TAG_W-1:0]         tag_o,
  input  logic                     fill_i,
  input  logic [TAG_W-1:0]         fill_tag_i,
  input  logic                     mark_i
);
  localparam int IDX_W = $clog2(SETS);

  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;
  logic [TAG_W-1:0] tag_q [SETS];

  // a mark in the same cycle as a fill wins (write-back allocate)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (idx_i == IDX_W'(s)) begin
          if (fill_i) begin
            valid_q[s] <= 1'b1;
            dirty_q[s] <= 1'b0;
            tag_q[s]   <= fill_tag_i;
          end
          if (mark_i) dirty_q[s] <= 1'b1;
        end
      end
    end
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];

  for (genvar s = 0; s < SETS; s++) begin : g_inv
    p_dirty_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dirty_q[s] |-> valid_q[s]);
  end

  p_fill_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i && !mark_i |=> valid_q[$past(idx_i)] && !dirty_q[$past(idx_i)]);

endmodule

// File: rtl/policy_cache_data.sv
module policy_cache_data #(
  parameter int SETS       = 8,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32
) (
  input  logic                           clk_i,
  input  logic [$clog2(SETS)-1:0]        idx_i,
  output logic [LINE_WORDS*DATA_W-1:0]   line_o,
  input  logic [LINE_WORDS-1:0]          wmask_i,
  input  logic [LINE_WORDS*DATA_W-1:0]   wline_i
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LINE_W = LINE_WORDS * DATA_W;

  logic [SETS-1:0][LINE_W-1:0] lines;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [LINE_W-1:0] line_q;
    always_ff @(posedge clk_i) begin
      for (int w = 0; w < LINE_WORDS; w++) begin
        if (wmask_i[w] && idx_i == IDX_W'(s))
          line_q[w*DATA_W +: DATA_W] <= wline_i[w*DATA_W +: DATA_W];
      end
    end
    assign lines[s] = line_q;
  end

  assign line_o = lines[idx_i];

endmodule

// File: rtl/policy_cache_ctrl.sv
module policy_cache_ctrl
  import policy_cache_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   wt_mode_i,
  input  logic                                   walloc_i,
  input  logic                                   cache_dis_i,
  input  logic                                   req_valid_i,
  output logic                                   req_ready_o,
  input  logic [ADDR_W-1:0]                      req_addr_i,
  input  logic                                   req_we_i,
  input  logic [DATA_W-1:0]                      req_wdata_i,
  output logic                                   rsp_valid_o,
  output logic [DATA_W-1:0]                      rsp_rdata_o,
  output logic                                   mem_req_o,
  output logic                                   mem_we_o,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]   mem_addr_o,
  output logic [LINE_WORDS-1:0]                  mem_wstrb_o,
  output logic [LINE_WORDS*DATA_W-1:0]           mem_wdata_o,
  input  logic                                   mem_ack_i,
  input  logic [LINE_WORDS*DATA_W-1:0]           mem_rdata_i,
  output logic [$clog2(SETS)-1:0]                idx_o,
  input  logic                                   tag_valid_i,
  input  logic                                   tag_dirty_i,
  input  logic [ADDR_W-$clog2(SETS)-$clog2(LINE_WORDS)-1:0] tag_i,
  output logic                                   fill_o,
  output logic [ADDR_W-$clog2(SETS)-$clog2(LINE_WORDS)-1:0] fill_tag_o,
  output logic                                   mark_o,
  input  logic [LINE_WORDS*DATA_W-1:0]           line_i,
  output logic [LINE_WORDS-1:0]                  wmask_o,
  output logic [LINE_WORDS*DATA_W-1:0]           wline_o
);
  localparam int OFS_W   = $clog2(LINE_WORDS);
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - IDX_W - OFS_W;
  localparam int LADDR_W = ADDR_W - OFS_W;
  localparam int LINE_W  = LINE_WORDS * DATA_W;

  pc_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wt_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  logic              idle;
  logic [ADDR_W-1:0] cur_addr;
  logic [OFS_W-1:0]  cur_off;
  logic [TAG_W-1:0]  cur_tag;
  logic [DATA_W-1:0] cur_wdata;
  logic              hit;
  logic [LINE_WORDS-1:0] word_mask;
  logic [DATA_W-1:0] hit_word, mem_word;
  logic [LINE_W-1:0] fill_line;
  logic              load_req, rsp_set;
  logic [DATA_W-1:0] rsp_data;

  assign idle      = (state_q == ST_IDLE);
  assign cur_addr  = idle ? req_addr_i : addr_q;
  assign cur_wdata = idle ? req_wdata_i : wdata_q;
  assign cur_off   = cur_addr[OFS_W-1:0];
  assign idx_o     = cur_addr[OFS_W +: IDX_W];
  assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];
  assign hit       = tag_valid_i && (tag_i == cur_tag);
  assign word_mask = LINE_WORDS'(1) << cur_off;
  assign hit_word  = line_i[cur_off*DATA_W +: DATA_W];
  assign mem_word  = mem_rdata_i[cur_off*DATA_W +: DATA_W];
  assign fill_tag_o = cur_tag;

  always_comb begin
    fill_line = mem_rdata_i;
    if (we_q) fill_line[cur_off*DATA_W +: DATA_W] = wdata_q;
  end

  always_comb begin
    state_d  = state_q;
    load_req = 1'b0;
    rsp_set  = 1'b0;
    rsp_data = rsp_rdata_q;
    fill_o   = 1'b0;
    mark_o   = 1'b0;
    wmask_o  = '0;
    wline_o  = {LINE_WORDS{cur_wdata}};
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          load_req = 1'b1;
          if (cache_dis_i) begin
            state_d = req_we_i ? ST_WORD_WR : ST_LINE_RD;
          end else if (hit) begin
            if (!req_we_i) begin
              rsp_set  = 1'b1;
              rsp_data = hit_word;
            end else begin
              wmask_o = word_mask;
              if (wt_mode_i) state_d = ST_WORD_WR;
              else begin
                mark_o  = 1'b1;
                rsp_set = 1'b1;
              end
            end
          end else if (req_we_i && !walloc_i) begin
            state_d = ST_WORD_WR;
          end else begin
            state_d = (tag_valid_i && tag_dirty_i) ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: if (mem_ack_i) state_d = ST_FILL;
      ST_FILL: begin
        if (mem_ack_i) begin
          fill_o  = 1'b1;
          wmask_o = '1;
          wline_o = fill_line;
          if (!we_q) begin
            rsp_set  = 1'b1;
            rsp_data = mem_word;
            state_d  = ST_IDLE;
          end else if (wt_q) begin
            state_d = ST_WORD_WR;
          end else begin
            mark_o  = 1'b1;
            rsp_set = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_WORD_WR: begin
        if (mem_ack_i) begin
          rsp_set = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_LINE_RD: begin
        if (mem_ack_i) begin
          rsp_set  = 1'b1;
          rsp_data = mem_word;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      wt_q        <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_set;
      if (rsp_set) rsp_rdata_q <= rsp_data;
      if (load_req) begin
        addr_q  <= req_addr_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
        wt_q    <= wt_mode_i;
      end
    end
  end

  assign req_ready_o = idle;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  assign mem_req_o   = (state_q == ST_EVICT) || (state_q == ST_FILL) ||
                       (state_q == ST_WORD_WR) || (state_q == ST_LINE_RD);
  assign mem_we_o    = (state_q == ST_EVICT) || (state_q == ST_WORD_WR);
  assign mem_addr_o  = (state_q == ST_EVICT) ? {tag_i, idx_o} : addr_q[ADDR_W-1 -: LADDR_W];
  assign mem_wdata_o = (state_q == ST_EVICT) ? line_i : {LINE_WORDS{wdata_q}};
  assign mem_wstrb_o = (state_q == ST_EVICT) ? '1 :
                       (state_q == ST_WORD_WR) ? word_mask : '0;

  p_mem_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wstrb_o));

  p_evict_dirty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_EVICT |-> tag_valid_i && tag_dirty_i);

  p_word_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WORD_WR |-> $countones(mem_wstrb_o) == 1);

  p_hit_fast_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !cache_dis_i && !req_we_i && hit
    |=> rsp_valid_o && rsp_rdata_o == $past(hit_word));

endmodule

// File: rtl/policy_cache.sv
module policy_cache #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wt_mode_i,
  input  logic                                 walloc_i,
  input  logic                                 cache_dis_i,
  input  logic                                 req_valid_i,
  output logic                                 req_ready_o,
  input  logic [ADDR_W-1:0]                    req_addr_i,
  input  logic                                 req_we_i,
  input  logic [DATA_W-1:0]                    req_wdata_i,
  output logic                                 rsp_valid_o,
  output logic [DATA_W-1:0]                    rsp_rdata_o,
  output logic                                 mem_req_o,
  output logic                                 mem_we_o,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] mem_addr_o,
  output logic [LINE_WORDS-1:0]                mem_wstrb_o,
  output logic [LINE_WORDS*DATA_W-1:0]         mem_wdata_o,
  input  logic                                 mem_ack_i,
  input  logic [LINE_WORDS*DATA_W-1:0]         mem_rdata_i
);
  localparam int OFS_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;
  localparam int LINE_W = LINE_WORDS * DATA_W;

  logic [IDX_W-1:0]      idx;
  logic                  tag_valid, tag_dirty, fill, mark;
  logic [TAG_W-1:0]      tag_rd, fill_tag;
  logic [LINE_W-1:0]     line_rd, wline;
  logic [LINE_WORDS-1:0] wmask;

  policy_cache_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (idx),
    .valid_o    (tag_valid),
    .dirty_o    (tag_dirty),
    .tag_o      (tag_rd),
    .fill_i     (fill),
    .fill_tag_i (fill_tag),
    .mark_i     (mark)
  );

  policy_cache_data #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk_i   (clk_i),
    .idx_i   (idx),
    .line_o  (line_rd),
    .wmask_i (wmask),
    .wline_i (wline)
  );

  policy_cache_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .SETS(SETS)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wt_mode_i   (wt_mode_i),
    .walloc_i    (walloc_i),
    .cache_dis_i (cache_dis_i),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_we_i    (req_we_i),
    .req_wdata_i (req_wdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wstrb_o (mem_wstrb_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .idx_o       (idx),
    .tag_valid_i (tag_valid),
    .tag_dirty_i (tag_dirty),
    .tag_i       (tag_rd),
    .fill_o      (fill),
    .fill_tag_o  (fill_tag),
    .mark_o      (mark),
    .line_i      (line_rd),
    .wmask_o     (wmask),
    .wline_o     (wline)
  );

endmodule

// File: tb/policy_cache_test.sv
module policy_cache_test;
  localparam int AW = 10, DW = 32, LW = 4, NS = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic m_wt = 0, m_wa = 0, m_dis = 0;
  logic req_valid = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [AW-3:0] mem_addr;
  logic [LW-1:0] mem_wstrb;
  logic [LW*DW-1:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  policy_cache #(.ADDR_W(AW), .DATA_W(DW), .LINE_WORDS(LW), .SETS(NS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wt_mode_i(m_wt), .walloc_i(m_wa), .cache_dis_i(m_dis),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_we_i(req_we), .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wstrb_o(mem_wstrb), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata));

  function automatic bit [31:0] seedw(int a);
    return {16'hC0DE, 6'd0, a[9:0]};
  endfunction

  // backing memory responder
  bit [31:0] mem_q [DEPTH];
  bit        mem_wr [DEPTH];
  int n_lw = 0, n_ww = 0, n_lr = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          for (int w = 0; w < LW; w++)
            if (mem_wstrb[w]) begin
              mem_q[{mem_addr, w[1:0]}]  <= mem_wdata[w*DW +: DW];
              mem_wr[{mem_addr, w[1:0]}] <= 1'b1;
            end
          if (&mem_wstrb) n_lw <= n_lw + 1;
          else n_ww <= n_ww + 1;
        end else begin
          for (int w = 0; w < LW; w++)
            mem_rdata[w*DW +: DW] <= mem_wr[{mem_addr, w[1:0]}] ?
                                     mem_q[{mem_addr, w[1:0]}] : seedw({22'd0, mem_addr, w[1:0]});
          n_lr <= n_lr + 1;
        end
      end
    end
  end

  // behavioural reference: flat backing memory plus one line per set
  bit [31:0] back [DEPTH];
  bit        cv [NS];
  bit        cdirty [NS];
  int        ct [NS];
  bit [31:0] cd [NS][LW];
  int e_lw, e_lr, e_ww;
  bit e_fast;
  bit [31:0] e_rd;
  string rq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic predict(int a, bit we, bit [31:0] wd);
    int s = (a >> 2) % NS;
    int t = a >> 5;
    int o = a % LW;
    e_lw = 0; e_lr = 0; e_ww = 0; e_fast = 0; e_rd = 0;
    if (m_dis) begin
      rq = "R9";
      if (we) begin back[a] = wd; e_ww = 1; end
      else begin e_lr = 1; e_rd = back[a]; end
    end else if (cv[s] && ct[s] == t) begin
      if (!we) begin rq = "R2"; e_rd = cd[s][o]; e_fast = 1; end
      else begin
        cd[s][o] = wd;
        if (m_wt) begin rq = "R4"; back[a] = wd; e_ww = 1; end
        else begin rq = "R5"; cdirty[s] = 1; e_fast = 1; end
      end
    end else if (we && !m_wa) begin
      rq = "R7"; back[a] = wd; e_ww = 1;
    end else begin
      rq = we ? "R8" : "R3";
      if (cv[s] && cdirty[s]) begin
        rq = "R6";
        for (int w = 0; w < LW; w++) back[(ct[s] << 5) | (s << 2) | w] = cd[s][w];
        e_lw = 1;
      end
      for (int w = 0; w < LW; w++) cd[s][w] = back[(t << 5) | (s << 2) | w];
      cv[s] = 1; ct[s] = t; cdirty[s] = 0; e_lr = 1;
      if (we) begin
        cd[s][o] = wd;
        if (m_wt) begin back[a] = wd; e_ww = 1; end else cdirty[s] = 1;
      end else e_rd = cd[s][o];
    end
  endtask

  task automatic access(int a, bit we, bit [31:0] wd, bit flip = 0, string over = "");
    int lw0, lr0, ww0, waits;
    bit rdy_busy;
    predict(a, we, wd);
    if (over != "") rq = over;
    @(negedge clk);
    lw0 = n_lw; lr0 = n_lr; ww0 = n_ww;
    req_valid = 1; req_addr = a[AW-1:0]; req_we = we; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    rdy_busy = req_ready;
    if (flip) m_wt = !m_wt;
    waits = 0;
    while (!rsp_valid && waits < 50) begin @(negedge clk); waits++; end
    if (flip) m_wt = !m_wt;
    chk(rsp_valid, rq, "response", rsp_valid, 1);
    chk(n_lw - lw0 == e_lw, rq, "line writes", n_lw - lw0, e_lw);
    chk(n_lr - lr0 == e_lr, rq, "line reads", n_lr - lr0, e_lr);
    chk(n_ww - ww0 == e_ww, rq, "word writes", n_ww - ww0, e_ww);
    if (!we) chk(rsp_rdata == e_rd, rq, "read data", rsp_rdata, e_rd);
    if (e_fast) chk(waits == 0, rq, "one-cycle response", waits, 0);
    else chk(!rdy_busy, "R11", "ready while busy", rdy_busy, 0);
  endtask

  task automatic do_reset();
    rst_n = 0; req_valid = 0;
    repeat (2) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R1", "state in reset",
        {req_ready, rsp_valid, mem_req}, 3'b100);
    rst_n = 1;
    for (int s = 0; s < NS; s++) begin cv[s] = 0; cdirty[s] = 0; end
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R1", "state after reset",
        {req_ready, rsp_valid, mem_req}, 3'b100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int mism;
    for (int a = 0; a < DEPTH; a++) back[a] = seedw(a);
    do_reset();

    // four policy combinations: directed then random
    for (int c = 0; c < 4; c++) begin
      m_wt = c[0]; m_wa = c[1];
      access(32'h010, 0, 0);                      // miss then hit
      access(32'h011, 0, 0);
      access(32'h012, 1, 32'h1111_0000 + c);
      access(32'h012, 0, 0);
      access(32'h032, 1, 32'h2222_0000 + c);      // same set, other tag
      access(32'h032, 0, 0);
      access(32'h012, 0, 0);
      for (int i = 0; i < 120; i++)
        access(($urandom % 4) * 32 + ($urandom % 32), 1'($urandom % 2), $urandom);
    end

    // R10: dirty line survives a switch to write-through
    m_wt = 0; m_wa = 1;
    access(32'h004, 1, 32'hD1D1_0004);
    m_wt = 1;
    access(32'h024, 0, 0, 0, "R10");

    // R12: policy change after acceptance is ignored
    m_wt = 1; m_wa = 1;
    access(32'h048, 1, 32'hAB12_0048, 1, "R12");

    // R9: disabled accesses neither see nor touch the cached dirty line
    m_wt = 0;
    access(32'h008, 1, 32'hCAFE_0008);
    m_dis = 1;
    access(32'h008, 0, 0);
    access(32'h008, 1, 32'hBEEF_0008);
    m_dis = 0;
    access(32'h008, 0, 0, 0, "R9");

    // R1: mid-run reset invalidates lines
    m_wt = 1;
    access(32'h00C, 0, 0);
    do_reset();
    access(32'h00C, 0, 0, 0, "R1");

    m_wt = 0; m_wa = 0;
    for (int i = 0; i < 60; i++)
      access(($urandom % 4) * 32 + ($urandom % 32), 1'($urandom % 2), $urandom);

    // push every dirty line out with reads to a fresh tag, then compare memory
    m_wt = 1;
    for (int s = 0; s < NS; s++) access(32'h3E0 | (s << 2), 0, 0);
    mism = 0;
    for (int a = 0; a < DEPTH; a++)
      if ((mem_wr[a] ? mem_q[a] : seedw(a)) != back[a]) mism++;
    chk(mism == 0, "R6", "backing memory mismatches", mism, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule